// File: doc/BRIEF.md
# Logic Cluster with Local Crossbar

This block is one configurable logic tile: eight logic elements, each a 4-input lookup table followed by a flip-flop, with a mode bit that picks whether the element's primary output is the table result or the stored bit. The stored bit is also sent out separately as a secondary output, but that signal never leaves the tile.

The four table inputs of every element come from a local crossbar. The crossbar has 32 small multiplexers, one per element input. Each multiplexer picks one of fifteen candidates. Six of these are cluster inputs, taken from a rotating window over the 18 shared inputs. Eight are the primary outputs of all eight elements. The fifteenth is one element's secondary output. The eight primary outputs form the cluster output bus.

All selects, tables and mode bits sit in one serial configuration chain. It is loaded while the user logic is idle (enable low). The elements share one clock, one active-low reset and one clock enable.

Top module: `lc_cluster`

## Requirements
- R1: After `rst_n` rises, `clu_out` reads 0 and the whole chain holds zeros. Shifting the chain out yields 0 on `cfg_dout` for all 264 positions. The internal reset stays active for two clock edges after `rst_n` rises.
- R2: On each clock with `cfg_shift` high, the chain advances one position. `cfg_din` enters position 0 and `cfg_dout` always shows position 263. With `cfg_shift` low, the chain holds its contents. The chain layout is as follows, where multiplexer m = 4e+p feeds pin p of element e:
  - Positions 4m+3..4m hold the select code of multiplexer m.
  - Positions 128+17e+15..128+17e hold the table of element e.
  - Position 128+17e+16 is the output mode of element e, where 1 means registered.
- R3: An element in combinational mode drives its table bit at index {p3,p2,p1,p0} onto its primary output in the same cycle.
- R4: Select codes 0 to 5 route cluster input number (3m + code) mod 18.
- R5: Select codes 6 to 13 route the primary output of element (code - 6).
- R6: Select code 14 routes the secondary (flip-flop) output of element (e + p) mod 8.
- R7: Select code 15 routes a constant 0.
- R8: On a clock edge with `ce` high, an element's flip-flop loads the table result; with `ce` low it holds. In registered mode, the primary output shows the flip-flop.
- R9: Driving `rst_n` low clears all flip-flops and the chain at once, without a clock edge, so `clu_out` and `cfg_dout` read 0.
- R10: While `cfg_shift` is high, every crossbar candidate that is a primary output reads 0. Cluster inputs and secondary outputs still pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flip-flops and the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce | input | 1 | Clock enable of all element flip-flops |
| cfg_shift | input | 1 | Advance the configuration chain one position per clock |
| cfg_din | input | 1 | Serial configuration data in |
| clu_in | input | 18 | Shared cluster inputs |
| clu_out | output | 8 | Primary outputs of the eight elements |
| cfg_dout | output | 1 | Last chain position, for cascading chains |

## Verification
Two things can happen on the same clock edge. An element's flip-flop captures a new value, and that same stored bit is used in that cycle through the crossbar. It reaches the element's own table through the secondary path (a toggling element) and a downstream combinational element through primary feedback. The registered configuration provokes this with `ce` toggled at random. A reference model recomputes every element each cycle from the requirements, and the scoreboard compares the whole output bus at mid-cycle. The second pairing is a configuration shift starting while combinational feedback is live. The first shift cycle is checked against a model with primary feedback cut.

// File: rtl/lc_pkg.sv
package lc_pkg;
  // Step of the rotating window of cluster inputs offered to successive muxes.
  localparam int unsigned IN_STEP = 3;

  // Cluster input number reached by candidate slot `slot` of mux `mux`.
  function automatic int unsigned in_pick(int unsigned mux, int unsigned slot,
                                          int unsigned n_in);
    return (IN_STEP * mux + slot) % n_in;
  endfunction
endpackage

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
  parameter int LEN = 264
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift,
  input  logic           din,
  output logic [LEN-1:0] bits,
  output logic           dout
);
  logic [LEN-1:0] bits_d;

  always_comb begin
    bits_d = bits;
    if (shift) bits_d = {bits[LEN-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else        bits <= bits_d;
  end

  assign dout = bits[LEN-1];

  assert_chain_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(bits));
  assert_chain_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> bits[0] == $past(din));
endmodule

// File: rtl/lc_ble.sv
module lc_ble #(
  parameter int K = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic [2**K-1:0] lut_cfg,
  input  logic            reg_mode,
  input  logic [K-1:0]    ins,
  output logic            prim,
  output logic            sec
);
  logic lut_o;
  logic q_r;
  logic q_d;

  assign lut_o = lut_cfg[ins];

  always_comb begin
    q_d = q_r;
    if (ce) q_d = lut_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign prim = reg_mode ? q_r : lut_o;
  assign sec  = q_r;

  assert_ff_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(sec));
  assert_ff_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> sec == $past(lut_o));
endmodule

// File: rtl/lc_xbar.sv
module lc_xbar #(
  parameter int N_IN   = 18,
  parameter int N_BLE  = 8,
  parameter int K      = 4,
  parameter int SEL_W  = 4,
  parameter int IN_SRC = 6
) (
  input  logic [N_IN-1:0]            cl_in,
  input  logic [N_BLE-1:0]           prim,
  input  logic [N_BLE-1:0]           sec,
  input  logic                       fb_block,
  input  logic [N_BLE*K*SEL_W-1:0]   sel,
  output logic [N_BLE*K-1:0]         pin
);
  localparam int N_MUX  = N_BLE * K;
  localparam int N_SRC  = IN_SRC + N_BLE + 1;
  localparam int N_CODE = 2 ** SEL_W;

  logic [N_BLE-1:0] prim_fb;
  assign prim_fb = fb_block ? '0 : prim;

  for (genvar m = 0; m < N_MUX; m++) begin : g_mux
    logic [N_CODE-1:0] src;
    logic [SEL_W-1:0]  code;
    assign code = sel[m*SEL_W +: SEL_W];
    for (genvar j = 0; j < IN_SRC; j++) begin : g_in
      assign src[j] = cl_in[lc_pkg::in_pick(m, j, N_IN)];
    end
    assign src[IN_SRC +: N_BLE] = prim_fb;
    assign src[IN_SRC+N_BLE]    = sec[((m / K) + (m % K)) % N_BLE];
    if (N_CODE > N_SRC) begin : g_pad
      assign src[N_CODE-1:N_SRC] = '0;
    end
    assign pin[m] = src[code];
  end
endmodule

// File: rtl/lc_cluster.sv
module lc_cluster #(
  parameter int N_BLE  = 8,
  parameter int K      = 4,
  parameter int N_IN   = 18,
  parameter int SEL_W  = 4,
  parameter int IN_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             cfg_shift,
  input  logic             cfg_din,
  input  logic [N_IN-1:0]  clu_in,
  output logic [N_BLE-1:0] clu_out,
  output logic             cfg_dout
);
  localparam int N_MUX   = N_BLE * K;
  localparam int XB_W    = N_MUX * SEL_W;
  localparam int LUT_W   = 2 ** K;
  localparam int BLE_W   = LUT_W + 1;
  localparam int CFG_LEN = XB_W + N_BLE * BLE_W;

  logic [1:0]         rst_s;
  logic [1:0]         rst_s_d;
  logic               rst_int;
  logic [CFG_LEN-1:0] cfg_bits;
  logic [N_MUX-1:0]   pin;
  logic [N_BLE-1:0]   prim;
  logic [N_BLE-1:0]   sec;

  assign rst_s_d = {rst_s[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_s <= '0;
    else        rst_s <= rst_s_d;
  end
  assign rst_int = rst_s[1];

  lc_cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk   (clk),
    .rst_n (rst_int),
    .shift (cfg_shift),
    .din   (cfg_din),
    .bits  (cfg_bits),
    .dout  (cfg_dout)
  );

  lc_xbar #(
    .N_IN(N_IN), .N_BLE(N_BLE), .K(K), .SEL_W(SEL_W), .IN_SRC(IN_SRC)
  ) u_xbar (
    .cl_in    (clu_in),
    .prim     (prim),
    .sec      (sec),
    .fb_block (cfg_shift),
    .sel      (cfg_bits[XB_W-1:0]),
    .pin      (pin)
  );

  for (genvar e = 0; e < N_BLE; e++) begin : g_ble
    lc_ble #(.K(K)) u_ble (
      .clk      (clk),
      .rst_n    (rst_int),
      .ce       (ce),
      .lut_cfg  (cfg_bits[XB_W + e*BLE_W +: LUT_W]),
      .reg_mode (cfg_bits[XB_W + e*BLE_W + LUT_W]),
      .ins      (pin[e*K +: K]),
      .prim     (prim[e]),
      .sec      (sec[e])
    );
  end

  assign clu_out = prim;

  assert_sec_quiet_R8: assert property (@(posedge clk) disable iff (!rst_int)
    !ce |=> $stable(sec));
  assert_dout_shift_R2: assert property (@(posedge clk) disable iff (!rst_int)
    cfg_shift |=> cfg_dout == $past(cfg_bits[CFG_LEN-2]));
endmodule

// File: tb/lc_cluster_tb.sv
module lc_cluster_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 8;
  localparam int NI  = 18;
  localparam int NM  = 32;
  localparam int XW  = 128;
  localparam int BW  = 17;
  localparam int TOT = XW + NB * BW;

  typedef struct {
    logic        chk_out;
    logic [7:0]  out;
    logic        dout;
    string       tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int fails  = 0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce;
  logic          cfg_shift;
  logic          cfg_din;
  logic [NI-1:0] clu_in;
  logic [NB-1:0] clu_out;
  logic          cfg_dout;

  lc_cluster u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .cfg_shift(cfg_shift),
    .cfg_din(cfg_din), .clu_in(clu_in), .clu_out(clu_out), .cfg_dout(cfg_dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  logic [3:0]     m_sel [NM];
  logic [15:0]    m_lut [NB];
  logic           m_reg [NB];
  logic [NB-1:0]  m_q;
  logic [TOT-1:0] m_chain;
  logic [3:0]     n_sel [NM];
  logic [15:0]    n_lut [NB];
  logic           n_reg [NB];

  function automatic logic [TOT-1:0] pack_next();
    logic [TOT-1:0] v = '0;
    for (int m = 0; m < NM; m++) v[4*m +: 4] = n_sel[m];
    for (int e = 0; e < NB; e++) begin
      v[XW + BW*e +: 16] = n_lut[e];
      v[XW + BW*e + 16]  = n_reg[e];
    end
    return v;
  endfunction

  task automatic unpack_model();
    for (int m = 0; m < NM; m++) m_sel[m] = m_chain[4*m +: 4];
    for (int e = 0; e < NB; e++) begin
      m_lut[e] = m_chain[XW + BW*e +: 16];
      m_reg[e] = m_chain[XW + BW*e + 16];
    end
  endtask

  task automatic clear_next();
    for (int m = 0; m < NM; m++) n_sel[m] = 4'd15;
    for (int e = 0; e < NB; e++) begin
      n_lut[e] = 16'h0000;
      n_reg[e] = 1'b0;
    end
  endtask

  function automatic logic src_val(int m, logic [3:0] code, logic [NI-1:0] inv,
                                   logic [NB-1:0] pr, logic blk);
    int c = int'(code);
    if (c < 6)       return inv[(3*m + c) % NI];          // R4
    else if (c < 14) return blk ? 1'b0 : pr[c-6];         // R5, R10
    else if (c == 14) return m_q[((m/4) + (m%4)) % NB];   // R6
    else             return 1'b0;                         // R7
  endfunction

  task automatic eval(input logic [NI-1:0] inv, input logic blk,
                      output logic [NB-1:0] pr, output logic [NB-1:0] lv);
    pr = '0;
    lv = '0;
    for (int pass = 0; pass <= NB; pass++) begin
      for (int e = 0; e < NB; e++) begin
        logic [3:0] idx;
        for (int p = 0; p < 4; p++) idx[p] = src_val(4*e+p, m_sel[4*e+p], inv, pr, blk);
        lv[e] = m_lut[e][idx];                            // R3
        pr[e] = m_reg[e] ? m_q[e] : lv[e];                // R8
      end
    end
  endtask

  task automatic push(input logic co, input logic [7:0] o, input logic d, input string t);
    item_t it;
    it.chk_out = co; it.out = o; it.dout = d; it.tag = t;
    sbq.push_back(it);
  endtask

  task automatic step(input logic [NI-1:0] inv, input logic cev, input string tag);
    logic [NB-1:0] pr, lv;
    @(posedge clk); #1;
    cfg_shift = 1'b0;
    clu_in = inv;
    ce = cev;
    eval(inv, 1'b0, pr, lv);
    push(1'b1, pr, m_chain[TOT-1], tag);
    if (cev) m_q = lv;
  endtask

  task automatic load(input logic [TOT-1:0] v, input logic [NI-1:0] inv);
    for (int i = TOT-1; i >= 0; i--) begin
      @(posedge clk); #1;
      ce = 1'b0;
      cfg_shift = 1'b1;
      cfg_din = v[i];
      if (i == TOT-1) begin
        logic [NB-1:0] pr, lv;
        clu_in = inv;
        eval(inv, 1'b1, pr, lv);
        push(1'b1, pr, m_chain[TOT-1], "R10");
      end else begin
        push(1'b0, 8'h00, m_chain[TOT-1], "R2");
      end
      m_chain = {m_chain[TOT-2:0], v[i]};
    end
    unpack_model();
  endtask

  task automatic model_reset();
    m_q = '0;
    m_chain = '0;
    unpack_model();
  endtask

  // Monitor: pops one expected item per cycle and compares at mid-cycle.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (cfg_dout !== it.dout) begin
        fails++;
        $display("FAIL %s: cfg_dout=%b expected %b", it.tag, cfg_dout, it.dout);
      end else if (it.chk_out && clu_out !== it.out) begin
        fails++;
        $display("FAIL %s: clu_out=%h expected %h", it.tag, clu_out, it.out);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce = 1'b0; cfg_shift = 1'b0; cfg_din = 1'b0; clu_in = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // r1_ reset state: outputs zero whatever the inputs
    for (int c = 0; c < 6; c++) step(NI'($urandom), 1'b1, "R1");

    // Combinational configuration: R3, R4, R5, R7
    clear_next();
    n_sel[0] = 4'd0; n_sel[1] = 4'd1; n_sel[2] = 4'd2; n_sel[3] = 4'd5; n_lut[0] = 16'hCAFE;
    n_sel[4] = 4'd3; n_sel[5] = 4'd4; n_sel[6] = 4'd5; n_sel[7] = 4'd0; n_lut[1] = 16'h9D27;
    n_sel[8] = 4'd6; n_sel[9] = 4'd7; n_sel[10] = 4'd13;               n_lut[2] = 16'h6E52;
    n_lut[3] = 16'h0001;
    n_sel[16] = 4'd12; n_lut[4] = 16'h5555;
    n_sel[24] = 4'd0;  n_lut[6] = 16'hAAAA;
    n_lut[7] = 16'h0001;
    load(pack_next(), NI'($urandom));
    for (int c = 0; c < 24; c++) step(NI'($urandom), 1'($urandom), "R3 R4 R5 R7");

    // Registered configuration, first shift cycle with live feedback: R2, R6, R8, R10
    clear_next();
    n_reg[0] = 1'b1; n_sel[0] = 4'd14; n_lut[0] = 16'h5555;
    n_reg[1] = 1'b1; n_sel[5] = 4'd14; n_lut[1] = 16'hCCCC;
    n_reg[2] = 1'b1; n_sel[8] = 4'd0;  n_lut[2] = 16'hAAAA;
    n_sel[12] = 4'd6; n_sel[13] = 4'd14; n_lut[3] = 16'h6666;
    n_reg[4] = 1'b1; n_sel[16] = 4'd8; n_lut[4] = 16'hAAAA;
    n_reg[5] = 1'b1; n_sel[20] = 4'd9; n_lut[5] = 16'hAAAA;
    load(pack_next(), 18'h00001);
    for (int c = 0; c < 40; c++) step(NI'($urandom), 1'($urandom), "R6 R8");
    for (int c = 0; c < 4; c++) step(NI'($urandom), 1'b0, "R8 hold");

    // Asynchronous reset mid-run: R9
    @(posedge clk); #1;
    rst_n = 1'b0;
    model_reset();
    #1 push(1'b1, 8'h00, 1'b0, "R9");
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) step(NI'($urandom), 1'b1, "R1");

    // Shift out after reset: every emitted bit zero (R1, R2)
    load(pack_next(), NI'($urandom));
    for (int c = 0; c < 10; c++) step(NI'($urandom), 1'($urandom), "R6 R8");

    @(posedge clk);
    @(posedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule